// File: doc/BRIEF.md
# I2S Master Bit-Clock and Word-Select Generator

This block is the timing source of an I2S controller running as clock master. It divides the system clock by a programmable integer to make a serial bit clock with a 50% duty cycle, and it drives the word-select line so that each sample frame carries a left slot and then a right slot. A 2-bit slot-length code sets how many bit-clock cycles each slot lasts: 16, 24 or 32. The bit-clock rate is therefore the sample rate times the slot length times two.

The generator runs only while both a global block enable and a dedicated clock enable are set. Clearing either one stops the clock and word-select lines at once and returns the block to idle. The next start always begins at a left slot with word-select low. The transmit and receive data paths do not decode the clock themselves. They use single-cycle strobes instead: one marks each falling bit-clock edge, where transmit data is launched, and one marks each rising edge, where receive data is sampled. A third strobe marks the return of word-select to the left slot, which is the frame boundary. A new slot-length code written while the block runs is held back until that boundary.

Top module: `i2s_ckgen`

## Requirements
- R1: After reset, and in every cycle after an edge at which `glb_en` and `sclk_en` are not both high, `sclk`, `ws`, `tx_stb`, `rx_stb` and `frame_stb` are all low.
- R2: While running with divider value D (a `div_half` of 0 is treated as 1), `sclk` starts low, rises after D running clock edges and then toggles every D edges, giving a period of 2·D system clocks at 50% duty.
- R3: `ws` is low for the first slot after a start and changes only together with a falling `sclk` edge. It toggles after every N falling edges, where N is decoded from `slot_code`: 0 gives 16, 1 gives 24, 2 and 3 give 32.
- R4: `tx_stb` is high for exactly the one cycle in which `sclk` has just gone from high to low, and at no other time.
- R5: `rx_stb` is high for exactly the one cycle in which `sclk` has just gone from low to high, and at no other time.
- R6: `frame_stb` is high for one cycle, in the cycle where `ws` has just returned from high to low at the end of a right slot.
- R7: The slot length follows `slot_code` continuously while idle. While running, the code is sampled only at the frame boundary, the same falling edge that raises `frame_stb`. A change in the middle of a frame does not alter that frame.
- R8: Setting `sclk_en` with `glb_en` low produces no clock activity. Clearing either enable in the middle of a frame stops the outputs, and the next start begins again with a full left slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| glb_en | input | 1 | Global block enable |
| sclk_en | input | 1 | Clock-generation enable |
| div_half | input | DIV_W | System clocks per half bit-clock period (0 acts as 1) |
| slot_code | input | 2 | Slot length: 0=16, 1=24, 2/3=32 bit clocks |
| sclk | output | 1 | Serial bit clock |
| ws | output | 1 | Word select, 0 = left slot, 1 = right slot |
| tx_stb | output | 1 | One-cycle strobe after each falling sclk edge |
| rx_stb | output | 1 | One-cycle strobe after each rising sclk edge |
| frame_stb | output | 1 | One-cycle strobe at each frame boundary |

## Verification
Every output is a register that changes at the same edge that samples the inputs. With D as the divider, `sclk` first rises at the D-th edge that sees both enables high. The strobes and any `ws` change are visible in the same cycle as the `sclk` change they belong to, and clearing an enable clears all outputs at the next edge. The bench drives inputs at the falling system-clock edge. After each rising edge it advances a model that counts only the running edges, computes the expected bit-clock phase and slot position arithmetically from that count, and compares all five outputs at the following falling edge. The slot-length code is latched the way R7 describes.

// File: rtl/i2s_ckgen_pkg.sv
package i2s_ckgen_pkg;

  localparam int unsigned LEN_W = 6;

  localparam logic [LEN_W-1:0] SLOT_SHORT = 6'd16;
  localparam logic [LEN_W-1:0] SLOT_MID   = 6'd24;
  localparam logic [LEN_W-1:0] SLOT_LONG  = 6'd32;

  typedef enum logic [1:0] {
    CODE_16 = 2'd0,
    CODE_24 = 2'd1,
    CODE_32 = 2'd2,
    CODE_RSV = 2'd3
  } slot_code_e;

  function automatic logic [LEN_W-1:0] slot_len(input logic [1:0] code);
    logic [LEN_W-1:0] len;
    case (slot_code_e'(code))
      CODE_16: len = SLOT_SHORT;
      CODE_24: len = SLOT_MID;
      default: len = SLOT_LONG;
    endcase
    return len;
  endfunction

endpackage

// File: rtl/i2s_ckgen_rst_sync.sv
module i2s_ckgen_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/i2s_ckgen_bclk.sv
module i2s_ckgen_bclk #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_half,
  output logic             fall_now,
  output logic             sclk,
  output logic             tx_stb,
  output logic             rx_stb
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             sclk_q, sclk_d;
  logic             tx_q, tx_d;
  logic             rx_q, rx_d;
  logic [DIV_W-1:0] div_m1;
  logic             wrap;

  // a zero divider behaves like one
  assign div_m1 = (div_half == '0) ? '0 : (div_half - 1'b1);
  // >= keeps the counter bounded if the ratio shrinks mid-count
  assign wrap     = run && (cnt_q >= div_m1);
  assign fall_now = wrap && sclk_q;

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    tx_d   = 1'b0;
    rx_d   = 1'b0;
    if (!run) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (wrap) begin
      cnt_d  = '0;
      sclk_d = ~sclk_q;
      tx_d   = sclk_q;
      rx_d   = ~sclk_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
      tx_q   <= 1'b0;
      rx_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
    end
  end

  assign sclk   = sclk_q;
  assign tx_stb = tx_q;
  assign rx_stb = rx_q;

endmodule

// File: rtl/i2s_ckgen_ws_seq.sv
module i2s_ckgen_ws_seq
  import i2s_ckgen_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       fall_now,
  input  logic [1:0] slot_code,
  output logic       ws,
  output logic       frame_stb
);

  logic [LEN_W-1:0] bitc_q, bitc_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             ws_q, ws_d;
  logic             frm_q, frm_d;
  logic             slot_end;

  assign slot_end = (bitc_q == (len_q - 1'b1));

  always_comb begin
    bitc_d = bitc_q;
    len_d  = len_q;
    ws_d   = ws_q;
    frm_d  = 1'b0;
    if (!run) begin
      bitc_d = '0;
      ws_d   = 1'b0;
      len_d  = slot_len(slot_code);
    end else if (fall_now) begin
      if (slot_end) begin
        bitc_d = '0;
        ws_d   = ~ws_q;
        if (ws_q) begin
          // right slot ends here: frame boundary, pick up the new length
          len_d = slot_len(slot_code);
          frm_d = 1'b1;
        end
      end else begin
        bitc_d = bitc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitc_q <= '0;
      len_q  <= SLOT_SHORT;
      ws_q   <= 1'b0;
      frm_q  <= 1'b0;
    end else begin
      bitc_q <= bitc_d;
      len_q  <= len_d;
      ws_q   <= ws_d;
      frm_q  <= frm_d;
    end
  end

  assign ws        = ws_q;
  assign frame_stb = frm_q;

endmodule

// File: rtl/i2s_ckgen.sv
module i2s_ckgen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             glb_en,
  input  logic             sclk_en,
  input  logic [DIV_W-1:0] div_half,
  input  logic [1:0]       slot_code,
  output logic             sclk,
  output logic             ws,
  output logic             tx_stb,
  output logic             rx_stb,
  output logic             frame_stb
);

  logic rst_int_n;
  logic run;
  logic fall_now;

  assign run = glb_en && sclk_en;

  i2s_ckgen_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  i2s_ckgen_bclk #(.DIV_W(DIV_W)) u_bclk (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run      (run),
    .div_half (div_half),
    .fall_now (fall_now),
    .sclk     (sclk),
    .tx_stb   (tx_stb),
    .rx_stb   (rx_stb)
  );

  i2s_ckgen_ws_seq u_ws (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .run       (run),
    .fall_now  (fall_now),
    .slot_code (slot_code),
    .ws        (ws),
    .frame_stb (frame_stb)
  );

endmodule

// File: rtl/i2s_ckgen_chk.sv
module i2s_ckgen_chk (
  input logic clk,
  input logic rst_n,
  input logic glb_en,
  input logic sclk_en,
  input logic sclk,
  input logic ws,
  input logic tx_stb,
  input logic rx_stb,
  input logic frame_stb
);

  // R1: any edge without both enables leaves every output low
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(glb_en && sclk_en) |=> (!sclk && !ws && !tx_stb && !rx_stb && !frame_stb));

  // R4: transmit strobe only right after a falling bit-clock edge
  a_r4_tx_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stb |-> (!sclk && $past(sclk)));

  // R5: receive strobe only right after a rising bit-clock edge
  a_r5_rx_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stb |-> (sclk && !$past(sclk)));

  // R3: a running word-select change travels with a falling edge
  a_r3_ws_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ((ws != $past(ws)) && $past(glb_en && sclk_en)) |-> tx_stb);

  // R6: frame strobe marks word-select returning to the left slot
  a_r6_frame_at_left: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |-> (!ws && $past(ws)));

endmodule

bind i2s_ckgen i2s_ckgen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .glb_en    (glb_en),
  .sclk_en   (sclk_en),
  .sclk      (sclk),
  .ws        (ws),
  .tx_stb    (tx_stb),
  .rx_stb    (rx_stb),
  .frame_stb (frame_stb)
);

// File: tb/i2s_ckgen_test.sv
module i2s_ckgen_test;

  localparam int DIV_W = 8;

  logic             clk;
  logic             rst_n;
  logic             glb_en;
  logic             sclk_en;
  logic [DIV_W-1:0] div_half;
  logic [1:0]       slot_code;
  logic             sclk, ws, tx_stb, rx_stb, frame_stb;

  int tests_run = 0;
  int tests_fail = 0;
  bit done = 1'b0;

  // model state
  int t;
  int fif;
  int len_cur;
  int e_sclk, e_ws, e_tx, e_rx, e_fr;

  i2s_ckgen #(.DIV_W(DIV_W)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .glb_en    (glb_en),
    .sclk_en   (sclk_en),
    .div_half  (div_half),
    .slot_code (slot_code),
    .sclk      (sclk),
    .ws        (ws),
    .tx_stb    (tx_stb),
    .rx_stb    (rx_stb),
    .frame_stb (frame_stb)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int len_of(input logic [1:0] c);
    if (c == 2'd0) return 16;
    if (c == 2'd1) return 24;
    return 32;
  endfunction

  function automatic int deff(input logic [DIV_W-1:0] d);
    return (d == 0) ? 1 : int'(d);
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    tests_run++;
    if (act != exp) begin
      tests_fail++;
      if (tests_fail <= 20)
        $display("FAIL %s %s at t=%0d: actual %0d expected %0d", tag, what, t, act, exp);
    end
  endtask

  // one system clock: advance model at the rising edge, compare at the falling edge
  task automatic step(input string tag);
    int d;
    int ph;
    @(posedge clk);
    d = deff(div_half);
    e_fr = 0; e_tx = 0; e_rx = 0;
    if (!(glb_en && sclk_en)) begin
      t = 0; fif = 0;
      len_cur = len_of(slot_code);
      e_sclk = 0; e_ws = 0;
    end else begin
      t++;
      ph = t % (2 * d);
      e_sclk = (t / d) % 2;
      e_tx = (ph == 0) ? 1 : 0;
      e_rx = (ph == d) ? 1 : 0;
      if (e_tx == 1) begin
        fif++;
        if (fif == 2 * len_cur) begin
          fif = 0;
          len_cur = len_of(slot_code);
          e_fr = 1;
        end
      end
      e_ws = (fif >= len_cur) ? 1 : 0;
    end
    @(negedge clk);
    chk(tag, "R2 sclk", int'(sclk), e_sclk);
    chk(tag, "R3 ws", int'(ws), e_ws);
    chk(tag, "R4 tx_stb", int'(tx_stb), e_tx);
    chk(tag, "R5 rx_stb", int'(rx_stb), e_rx);
    chk(tag, "R6 frame_stb", int'(frame_stb), e_fr);
  endtask

  task automatic run_for(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    void'($urandom(32'h5eed_12c5));
    rst_n = 1'b0; glb_en = 1'b0; sclk_en = 1'b0;
    div_half = 8'd1; slot_code = 2'd0;
    t = 0; fif = 0; len_cur = 16;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "reset sclk", int'(sclk), 0);
    chk("R1", "reset ws", int'(ws), 0);
    chk("R1", "reset strobes", int'({tx_stb, rx_stb, frame_stb}), 0);
    rst_n = 1'b1;
    run_for("R1", 4);

    // R2 R3: fastest divider, 16-bit slots, several frames
    glb_en = 1'b1; sclk_en = 1'b1;
    run_for("R3", 2 * 1 * 16 * 2 * 3);

    // R8: stop mid-frame, then restart with a fresh left slot
    sclk_en = 1'b0;
    run_for("R8", 3);
    div_half = 8'd3; slot_code = 2'd1;
    sclk_en = 1'b1;
    run_for("R2", 2 * 3 * 24 * 2 * 2 + 10);

    // R8: clock enable alone, global enable off
    glb_en = 1'b0;
    run_for("R8", 40);

    // R7: slot length change in the middle of a frame
    div_half = 8'd2; slot_code = 2'd2;
    glb_en = 1'b1;
    run_for("R7", 2 * 2 * 10);
    slot_code = 2'd0;
    run_for("R7", 2 * 2 * 32 * 2 + 2 * 2 * 16 * 2 * 2);

    // R2: zero divider acts as one; R3: reserved code gives 32
    glb_en = 1'b0;
    run_for("R1", 2);
    div_half = 8'd0; slot_code = 2'd3;
    glb_en = 1'b1;
    run_for("R2", 2 * 32 * 2 * 2 + 5);

    // random runs with random divider, code and mid-run code changes
    for (int r = 0; r < 12; r++) begin
      glb_en = 1'b0; sclk_en = 1'b0;
      run_for("R1", 1 + ($urandom % 3));
      div_half = 8'($urandom % 5);
      slot_code = 2'($urandom % 4);
      glb_en = 1'b1; sclk_en = 1'b1;
      for (int k = 0; k < 6; k++) begin
        run_for("R7", 50 + ($urandom % 300));
        slot_code = 2'($urandom % 4);
      end
      if ($urandom % 2 == 0) glb_en = 1'b0; else sclk_en = 1'b0;
      run_for("R8", 5);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests_run++;
      tests_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_fail);
      $finish;
    end
  end

endmodule